// File: doc/BRIEF.md
# Leveler Fault Monitor

This block watches an amplitude leveling loop and decides when the loop has failed. On each cycle that carries a sample it looks at three values: the loop error, the drive level the loop applies to its actuator, and a pair made of the measured output power and the commanded power. It reports a single active-low fault status. A chip carries one instance for each leveler it has, for example one for a high-power path and one for a low-power path.

Each of the three failure criteria must hold for longer than the leveler's response time, counted in samples, before it can declare a fault. A brief glitch therefore cannot raise the status. The power comparison also waits for the loop to settle after each change of the commanded power. Once the fault is declared it stays latched, and three sticky cause flags record which criteria tripped. An explicit clear input or reset removes the fault and the flags.

Top module: `lvl_fault_mon`

## Requirements
- R1: After reset, and after any later reset, faultN is 1 and all three cause flags are 0.
- R2: The error criterion trips when |loopErr| (loopErr is two's complement) is strictly greater than errThresh on respTime+1 consecutive valid samples. On the clock edge of the last of those samples, faultN goes to 0 and flagErr goes to 1. An error equal to the threshold does not count.
- R3: Each criterion has its own persistence count. A valid sample on which the condition is false restarts that count from zero.
- R4: Cycles with sampleValid low neither advance nor restart any count or the settling timer, and they change neither the status nor the flags.
- R5: The drive criterion trips when driveLevel is strictly greater than driveMax on respTime+1 consecutive valid samples. It then sets flagDrive and drives faultN to 0.
- R6: The power criterion trips when |pwrMeas - pwrCmd| is strictly greater than pwrTol on respTime+1 consecutive qualified samples. It then sets flagPower and drives faultN to 0. A difference equal to pwrTol does not count.
- R7: A valid sample on which pwrCmd differs from its value at the previous valid sample restarts the settling timer. That sample and the next respTime valid samples are not qualified for the power criterion. Reset also starts the settling timer, with a previous command of 0.
- R8: The fault stays latched after the conditions go away. An asserted clearFault sets faultN to 1, clears the flags and zeroes the persistence counts on that edge, and it takes priority over any trip in the same cycle.
- R9: The flags are sticky and independent. When several criteria trip together, each of them is recorded. faultN is 0 exactly when at least one flag is set.
- R10: With respTime equal to 0, a single valid sample meeting a condition trips it. The power criterion then trips on the first valid sample after a command change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sampleValid | input | 1 | Marks the cycles that carry a sample |
| loopErr | input | ERR_W | Signed loop error sample |
| driveLevel | input | DRV_W | Unsigned loop drive level |
| pwrMeas | input | PWR_W | Measured output power |
| pwrCmd | input | PWR_W | Commanded output power |
| errThresh | input | ERR_W | Error magnitude threshold |
| driveMax | input | DRV_W | Maximum allowed drive level |
| pwrTol | input | PWR_W | Allowed power difference |
| respTime | input | CNT_W | Leveler response time in samples |
| clearFault | input | 1 | Synchronous clear of the fault and flags |
| faultN | output | 1 | Active-low fault status |
| flagErr | output | 1 | Sticky: the error criterion tripped |
| flagDrive | output | 1 | Sticky: the drive criterion tripped |
| flagPower | output | 1 | Sticky: the power criterion tripped |

## Verification
The error criterion is driven with runs of positive and negative errors, including one run that reaches exactly the threshold. These runs separate a correct magnitude comparison from a signed one or a non-strict one. Runs are broken by an invalid cycle, which must not count, and by a below-threshold sample, which must restart the count. Together they show whether the persistence count is gated by the strobe and restarted when the condition clears. A change of the power command with a large difference is traced sample by sample to locate the exact trip edge, which shows that the settling window and the persistence window are applied in sequence. Simultaneous drive and error conditions, a zero response time and a mid-run reset cover flag independence and the edge cases.

// File: rtl/lvl_fault_pkg.sv
package lvl_fault_pkg;
  localparam int CRIT_ERR   = 0;
  localparam int CRIT_DRIVE = 1;
  localparam int CRIT_POWER = 2;
  localparam int NUM_CRIT   = 3;

  // control -> datapath
  typedef struct packed {
    logic takeCmd;
  } lvlStrobe_t;

  // datapath -> control
  typedef struct packed {
    logic errHigh;
    logic driveHigh;
    logic pwrOff;
    logic cmdChg;
  } lvlCond_t;
endpackage

// File: rtl/lvl_fault_dp.sv
module lvl_fault_dp
  import lvl_fault_pkg::*;
#(
  parameter int ERR_W = 12,
  parameter int DRV_W = 12,
  parameter int PWR_W = 12
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  lvlStrobe_t              strobe,
  input  logic signed [ERR_W-1:0] loopErr,
  input  logic [DRV_W-1:0]        driveLevel,
  input  logic [PWR_W-1:0]        pwrMeas,
  input  logic [PWR_W-1:0]        pwrCmd,
  input  logic [ERR_W-1:0]        errThresh,
  input  logic [DRV_W-1:0]        driveMax,
  input  logic [PWR_W-1:0]        pwrTol,
  output lvlCond_t                cond
);
  localparam int EMAG_W = ERR_W + 1;
  localparam int PDIF_W = PWR_W + 1;

  logic signed [EMAG_W-1:0] errExt;
  logic [EMAG_W-1:0]        errMag;
  logic signed [PDIF_W-1:0] pwrDiff;
  logic [PDIF_W-1:0]        pwrMag;
  logic [PWR_W-1:0]         lastCmd;

  always_comb begin
    errExt  = EMAG_W'(loopErr);
    errMag  = errExt[EMAG_W-1] ? EMAG_W'(-errExt) : EMAG_W'(errExt);
    pwrDiff = $signed({1'b0, pwrMeas}) - $signed({1'b0, pwrCmd});
    pwrMag  = pwrDiff[PDIF_W-1] ? PDIF_W'(-pwrDiff) : PDIF_W'(pwrDiff);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              lastCmd <= '0;
    else if (strobe.takeCmd) lastCmd <= pwrCmd;
  end

  assign cond.errHigh   = errMag > {1'b0, errThresh};
  assign cond.driveHigh = driveLevel > driveMax;
  assign cond.pwrOff    = pwrMag > {1'b0, pwrTol};
  assign cond.cmdChg    = pwrCmd != lastCmd;
endmodule

// File: rtl/lvl_fault_ctrl.sv
module lvl_fault_ctrl
  import lvl_fault_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sampleValid,
  input  logic                clearFault,
  input  logic [CNT_W-1:0]    respTime,
  input  lvlCond_t            cond,
  output lvlStrobe_t          strobe,
  output logic                faultN,
  output logic [NUM_CRIT-1:0] flags
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0]    settleCnt;
  logic                settled;
  logic [NUM_CRIT-1:0] condVec;
  logic [NUM_CRIT-1:0] trip;

  assign strobe.takeCmd = sampleValid;
  assign settled        = settleCnt >= respTime;

  always_comb begin
    condVec             = '0;
    condVec[CRIT_ERR]   = cond.errHigh;
    condVec[CRIT_DRIVE] = cond.driveHigh;
    condVec[CRIT_POWER] = cond.pwrOff && settled && !cond.cmdChg;
  end

  // settling window after a command change
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                settleCnt <= '0;
    else if (sampleValid) begin
      if (cond.cmdChg)         settleCnt <= '0;
      else if (!settled)       settleCnt <= settleCnt + 1'b1;
    end
  end

  for (genvar i = 0; i < NUM_CRIT; i++) begin : g_persist
    logic [CNT_W-1:0] runCnt;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            runCnt <= '0;
      else if (clearFault)   runCnt <= '0;
      else if (sampleValid) begin
        if (!condVec[i])     runCnt <= '0;
        else if (runCnt != CNT_MAX) runCnt <= runCnt + 1'b1;
      end
    end
    assign trip[i] = sampleValid && condVec[i] && (runCnt >= respTime);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      faultN <= 1'b1;
      flags  <= '0;
    end else if (clearFault) begin
      faultN <= 1'b1;
      flags  <= '0;
    end else begin
      flags  <= flags | trip;
      faultN <= faultN & ~(|trip);
    end
  end
endmodule

// File: rtl/lvl_fault_mon.sv
module lvl_fault_mon
  import lvl_fault_pkg::*;
#(
  parameter int ERR_W = 12,
  parameter int DRV_W = 12,
  parameter int PWR_W = 12,
  parameter int CNT_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    sampleValid,
  input  logic signed [ERR_W-1:0] loopErr,
  input  logic [DRV_W-1:0]        driveLevel,
  input  logic [PWR_W-1:0]        pwrMeas,
  input  logic [PWR_W-1:0]        pwrCmd,
  input  logic [ERR_W-1:0]        errThresh,
  input  logic [DRV_W-1:0]        driveMax,
  input  logic [PWR_W-1:0]        pwrTol,
  input  logic [CNT_W-1:0]        respTime,
  input  logic                    clearFault,
  output logic                    faultN,
  output logic                    flagErr,
  output logic                    flagDrive,
  output logic                    flagPower
);
  lvlStrobe_t          strobe;
  lvlCond_t            cond;
  logic [NUM_CRIT-1:0] flags;

  lvl_fault_dp #(.ERR_W(ERR_W), .DRV_W(DRV_W), .PWR_W(PWR_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe),
    .loopErr(loopErr), .driveLevel(driveLevel),
    .pwrMeas(pwrMeas), .pwrCmd(pwrCmd),
    .errThresh(errThresh), .driveMax(driveMax), .pwrTol(pwrTol),
    .cond(cond)
  );

  lvl_fault_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .sampleValid(sampleValid),
    .clearFault(clearFault), .respTime(respTime), .cond(cond),
    .strobe(strobe), .faultN(faultN), .flags(flags)
  );

  assign flagErr   = flags[CRIT_ERR];
  assign flagDrive = flags[CRIT_DRIVE];
  assign flagPower = flags[CRIT_POWER];
endmodule

// File: rtl/lvl_fault_mon_chk.sv
module lvl_fault_mon_chk #(
  parameter int DRV_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sampleValid,
  input logic             clearFault,
  input logic [DRV_W-1:0] driveLevel,
  input logic [DRV_W-1:0] driveMax,
  input logic             faultN,
  input logic             flagErr,
  input logic             flagDrive,
  input logic             flagPower
);
  logic [2:0] flagBus;
  assign flagBus = {flagPower, flagDrive, flagErr};

  // R8: clear wins over everything on its edge
  p_clear_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clearFault |=> (faultN && flagBus == 3'b000));

  // R8: a declared fault holds until cleared
  p_fault_latched_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!faultN && !clearFault) |=> !faultN);

  // R9: status and flags agree
  p_status_flags_r9: assert property (@(posedge clk) disable iff (!rst_n)
    faultN == (flagBus == 3'b000));

  // R4: no sample, no change
  p_idle_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!sampleValid && !clearFault) |=> ($stable(faultN) && $stable(flagBus)));

  // R2: error flag rises only on a sampled cycle
  p_err_sampled_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flagErr) |-> $past(sampleValid));

  // R5: drive flag rises only when the drive was above its limit
  p_drive_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flagDrive) |-> $past(driveLevel > driveMax));
endmodule

bind lvl_fault_mon lvl_fault_mon_chk #(.DRV_W(DRV_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sampleValid(sampleValid),
  .clearFault(clearFault), .driveLevel(driveLevel), .driveMax(driveMax),
  .faultN(faultN), .flagErr(flagErr), .flagDrive(flagDrive),
  .flagPower(flagPower)
);

// File: tb/sim_lvl_fault_mon.sv
module sim_lvl_fault_mon;
  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              sampleValid = 1'b0;
  logic signed [11:0] loopErr = '0;
  logic [11:0]       driveLevel = '0;
  logic [11:0]       pwrMeas = '0;
  logic [11:0]       pwrCmd = '0;
  logic [11:0]       errThresh = 12'd100;
  logic [11:0]       driveMax = 12'd3000;
  logic [11:0]       pwrTol = 12'd20;
  logic [7:0]        respTime = 8'd3;
  logic              clearFault = 1'b0;
  logic              faultN, flagErr, flagDrive, flagPower;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  lvl_fault_mon u0 (
    .clk(clk), .rst_n(rst_n), .sampleValid(sampleValid),
    .loopErr(loopErr), .driveLevel(driveLevel), .pwrMeas(pwrMeas),
    .pwrCmd(pwrCmd), .errThresh(errThresh), .driveMax(driveMax),
    .pwrTol(pwrTol), .respTime(respTime), .clearFault(clearFault),
    .faultN(faultN), .flagErr(flagErr), .flagDrive(flagDrive),
    .flagPower(flagPower)
  );

  // row: valid | err | drive | meas | cmd | clear | expFaultN | expFlags{pwr,drv,err} | tag
  localparam int NROW = 45;
  localparam logic [57:0] TBL [NROW] = '{
    {1'b1,12'd150,12'd0,12'd0,12'd0,1'b0,1'b1,3'b000,4'd2},   // 0  R2 run 1
    {1'b1,12'd150,12'd0,12'd0,12'd0,1'b0,1'b1,3'b000,4'd2},   // 1
    {1'b1,12'hF6A,12'd0,12'd0,12'd0,1'b0,1'b1,3'b000,4'd2},   // 2  -150
    {1'b0,12'd150,12'd0,12'd0,12'd0,1'b0,1'b1,3'b000,4'd4},   // 3  R4 gap
    {1'b1,12'd150,12'd0,12'd0,12'd0,1'b0,1'b0,3'b001,4'd2},   // 4  trip
    {1'b1,12'd0,12'd0,12'd0,12'd0,1'b0,1'b0,3'b001,4'd8},     // 5  R8 latch
    {1'b0,12'd0,12'd0,12'd0,12'd0,1'b1,1'b1,3'b000,4'd8},     // 6  clear
    {1'b1,12'd150,12'd0,12'd0,12'd0,1'b0,1'b1,3'b000,4'd3},   // 7  R3
    {1'b1,12'd150,12'd0,12'd0,12'd0,1'b0,1'b1,3'b000,4'd3},   // 8
    {1'b1,12'd100,12'd0,12'd0,12'd0,1'b0,1'b1,3'b000,4'd3},   // 9  equal: restart
    {1'b1,12'd150,12'd0,12'd0,12'd0,1'b0,1'b1,3'b000,4'd3},   // 10
    {1'b1,12'd150,12'd0,12'd0,12'd0,1'b0,1'b1,3'b000,4'd3},   // 11
    {1'b1,12'd150,12'd0,12'd0,12'd0,1'b0,1'b1,3'b000,4'd3},   // 12
    {1'b1,12'hF9B,12'd0,12'd0,12'd0,1'b0,1'b0,3'b001,4'd3},   // 13 -101 trip
    {1'b1,12'd150,12'd0,12'd0,12'd0,1'b1,1'b1,3'b000,4'd8},   // 14 clear priority
    {1'b1,12'd0,12'd3001,12'd0,12'd0,1'b0,1'b1,3'b000,4'd5},  // 15 R5
    {1'b1,12'd0,12'd3001,12'd0,12'd0,1'b0,1'b1,3'b000,4'd5},  // 16
    {1'b1,12'd0,12'd3001,12'd0,12'd0,1'b0,1'b1,3'b000,4'd5},  // 17
    {1'b1,12'd0,12'd3001,12'd0,12'd0,1'b0,1'b0,3'b010,4'd5},  // 18 trip
    {1'b1,12'd0,12'd3000,12'd0,12'd0,1'b0,1'b0,3'b010,4'd8},  // 19
    {1'b0,12'd0,12'd0,12'd0,12'd0,1'b1,1'b1,3'b000,4'd8},     // 20 clear
    {1'b1,12'd0,12'd0,12'd50,12'd0,1'b0,1'b1,3'b000,4'd6},    // 21 R6
    {1'b1,12'd0,12'd0,12'd50,12'd0,1'b0,1'b1,3'b000,4'd6},    // 22
    {1'b1,12'd0,12'd0,12'd50,12'd0,1'b0,1'b1,3'b000,4'd6},    // 23
    {1'b1,12'd0,12'd0,12'd50,12'd0,1'b0,1'b0,3'b100,4'd6},    // 24 trip
    {1'b0,12'd0,12'd0,12'd0,12'd0,1'b1,1'b1,3'b000,4'd8},     // 25 clear
    {1'b1,12'd0,12'd0,12'd100,12'd40,1'b0,1'b1,3'b000,4'd7},  // 26 R7 cmd change
    {1'b1,12'd0,12'd0,12'd100,12'd40,1'b0,1'b1,3'b000,4'd7},  // 27 settling
    {1'b1,12'd0,12'd0,12'd100,12'd40,1'b0,1'b1,3'b000,4'd7},  // 28
    {1'b1,12'd0,12'd0,12'd100,12'd40,1'b0,1'b1,3'b000,4'd7},  // 29
    {1'b1,12'd0,12'd0,12'd100,12'd40,1'b0,1'b1,3'b000,4'd7},  // 30 qualified 1
    {1'b1,12'd0,12'd0,12'd100,12'd40,1'b0,1'b1,3'b000,4'd7},  // 31
    {1'b1,12'd0,12'd0,12'd100,12'd40,1'b0,1'b1,3'b000,4'd7},  // 32
    {1'b1,12'd0,12'd0,12'd100,12'd40,1'b0,1'b0,3'b100,4'd7},  // 33 trip
    {1'b0,12'd0,12'd0,12'd40,12'd40,1'b1,1'b1,3'b000,4'd8},   // 34 clear
    {1'b1,12'd150,12'd3001,12'd40,12'd40,1'b0,1'b1,3'b000,4'd9}, // 35 R9
    {1'b1,12'd150,12'd3001,12'd40,12'd40,1'b0,1'b1,3'b000,4'd9}, // 36
    {1'b1,12'd150,12'd3001,12'd40,12'd40,1'b0,1'b1,3'b000,4'd9}, // 37
    {1'b1,12'd150,12'd3001,12'd40,12'd40,1'b0,1'b0,3'b011,4'd9}, // 38 both
    {1'b0,12'd0,12'd0,12'd40,12'd40,1'b1,1'b1,3'b000,4'd8},   // 39 clear
    {1'b1,12'd0,12'd0,12'd60,12'd40,1'b0,1'b1,3'b000,4'd6},   // 40 diff == tol
    {1'b1,12'd0,12'd0,12'd60,12'd40,1'b0,1'b1,3'b000,4'd6},   // 41
    {1'b1,12'd0,12'd0,12'd60,12'd40,1'b0,1'b1,3'b000,4'd6},   // 42
    {1'b1,12'd0,12'd0,12'd60,12'd40,1'b0,1'b1,3'b000,4'd6},   // 43
    {1'b1,12'd0,12'd0,12'd60,12'd40,1'b0,1'b1,3'b000,4'd6}    // 44
  };

  task automatic check(input string req, input logic [3:0] expv);
    logic [3:0] act;
    act = {faultN, flagPower, flagDrive, flagErr};
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s: {faultN,pwr,drv,err} actual %b expected %b at %0t",
               req, act, expv, $time);
    end
  endtask

  task automatic apply(input logic v, input logic [11:0] e, input logic [11:0] d,
                       input logic [11:0] m, input logic [11:0] c, input logic clr);
    @(negedge clk);
    sampleValid = v; loopErr = e; driveLevel = d;
    pwrMeas = m; pwrCmd = c; clearFault = clr;
    @(posedge clk);
    #1;
  endtask

  initial begin
    #(200_000 * 10);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset state", 4'b1000);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NROW; i++) begin
      logic [57:0] r;
      string tag;
      r = TBL[i];
      apply(r[57], r[56:45], r[44:33], r[32:21], r[20:9], r[8]);
      tag = $sformatf("R%0d row %0d", r[3:0], i);
      check(tag, r[7:4]);
    end

    // R1: a reset in the middle of a run removes a latched fault
    for (int k = 0; k < 4; k++) apply(1'b1, 12'd0, 12'd3001, 12'd40, 12'd40, 1'b0);
    check("R5 drive trip before reset", 4'b0010);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1 mid-run reset", 4'b1000);
    @(negedge clk);
    rst_n = 1'b1;
    apply(1'b0, 12'd0, 12'd0, 12'd0, 12'd0, 1'b0);
    check("R1 idle after reset", 4'b1000);

    // R10: zero response time
    respTime = 8'd0;
    apply(1'b1, 12'd0, 12'd3001, 12'd0, 12'd0, 1'b0);
    check("R10 single drive sample trips", 4'b0010);
    apply(1'b0, 12'd0, 12'd0, 12'd0, 12'd0, 1'b1);
    check("R10 clear", 4'b1000);
    apply(1'b1, 12'd0, 12'd0, 12'd100, 12'd7, 1'b0);
    check("R10 command change sample not qualified", 4'b1000);
    apply(1'b1, 12'd0, 12'd0, 12'd100, 12'd7, 1'b0);
    check("R10 power trips next sample", 4'b0100);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule